// File: doc/BRIEF.md
# PN-Code Direct-Sequence Spreader

This block turns a short message word into a direct-sequence spread frame. A four-stage linear feedback shift register produces a maximal-length code of fifteen chips. Each message bit is combined with one whole code period by XNOR, so a one sends the code unchanged and a zero sends its complement. With the default four-bit message, the four segments join into a frame of sixty chips.

A request on `start` while the block is idle captures the message. The chips then appear one per clock on `chip_out`, qualified by `chip_valid`. Once the last chip has been sent, `frame_done` pulses for one cycle. At that point the whole frame is also available in parallel on `frame_out`, and it stays there until the next request is accepted. The code generator restarts from its seed at the start of every message bit, so every segment carries the same code phase.

Top module: `dsss_spreader`

## Requirements
- R1: While and right after reset, `chip_valid` and `frame_done` are 0 and `frame_out` is all zeros.
- R2: The code period, first chip to last, is 0,0,1,0,0,0,1,1,1,1,0,1,0,1,1 and obeys c[n+4] = c[n] XOR c[n+3]. Every message bit's segment starts from the first chip of this period.
- R3: The code generator state is never all zeros. Reset and every segment start load a nonzero seed.
- R4: Each chip equals message bit XNOR code chip: a message 1 sends the code as is, a message 0 sends its complement (message 1010 gives code, complement, code, complement).
- R5: The message MSB is spread first. In `frame_out`, bit 59 holds the first chip sent and bit 0 the last, so bits 59..45 carry the MSB's segment.
- R6: A `start` sampled high while idle makes `chip_valid` high from the next cycle for exactly 60 consecutive cycles, with one new chip on `chip_out` in each of them.
- R7: `frame_done` is high for exactly one cycle, the one right after the 60th chip. In that cycle `frame_out` holds the full frame, and it keeps that value until the next accepted `start`.
- R8: A `start` sampled while chips are being sent or while `frame_done` is high is ignored. The frame in progress keeps its message, and no new frame follows.
- R9: With no `start`, an idle block keeps `chip_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to spread `msg_in`; taken only when idle |
| msg_in | input | 4 | Message word, MSB spread first |
| chip_out | output | 1 | Current serial chip |
| chip_valid | output | 1 | High while `chip_out` carries a chip |
| frame_done | output | 1 | One-cycle pulse after the last chip |
| frame_out | output | 60 | Parallel frame, first chip in bit 59 |

## Verification
The completion pulse and an incoming request can fall in the same cycle. A request that is still high in the final chip cycle and in the `frame_done` cycle must not start a second frame. The bench provokes this by raising `start`, with a different message, during the last chip and holding it through the completion cycle. Once `start` drops, it expects `chip_valid` to stay low and `frame_out` to keep the finished frame. A separate check makes the same request in the middle of a segment and compares every chip against the original message.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

    localparam int unsigned MSG_W   = 4;
    localparam int unsigned PN_W    = 4;
    localparam int unsigned PN_LEN  = (1 << PN_W) - 1;
    localparam int unsigned FRAME_W = MSG_W * PN_LEN;

    // Tap mask over the state; state[0] is the chip leaving the register.
    localparam logic [PN_W-1:0] PN_TAPS = 4'b1001;
    // Seed giving the period 0010 0011 1101 011 from state[0].
    localparam logic [PN_W-1:0] PN_SEED = 4'b0100;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_DONE = 2'd2
    } tx_state_e;

    function automatic logic [PN_W-1:0] pn_step(
        input logic [PN_W-1:0] s,
        input logic [PN_W-1:0] taps
    );
        logic fb;
        fb = ^(s & taps);
        return {fb, s[PN_W-1:1]};
    endfunction

    function automatic logic [PN_W-1:0] pn_safe_seed(input logic [PN_W-1:0] s);
        return (s == '0) ? {{(PN_W-1){1'b0}}, 1'b1} : s;
    endfunction

endpackage

// File: rtl/dsss_pn_gen.sv
module dsss_pn_gen
    import dsss_pkg::*;
#(
    parameter int unsigned W = PN_W,
    parameter logic [W-1:0] TAPS = PN_TAPS,
    parameter logic [W-1:0] SEED = PN_SEED
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         advance,
    output logic [W-1:0] state,
    output logic         chip
);

    localparam logic [W-1:0] SEED_OK = (SEED == '0) ? {{(W-1){1'b0}}, 1'b1} : SEED;

    logic [W-1:0] nxt;

    always_comb begin
        nxt = {^(state & TAPS), state[W-1:1]};
        if (nxt == '0) nxt = SEED_OK;
    end

    always_ff @(posedge clk) begin
        if (rst)          state <= SEED_OK;
        else if (restart) state <= SEED_OK;
        else if (advance) state <= nxt;
    end

    assign chip = state[0];

    // R3: the register never holds the lockup value
    a_r3_never_zero: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/dsss_seq_ctrl.sv
module dsss_seq_ctrl
    import dsss_pkg::*;
#(
    parameter int unsigned NBITS = MSG_W,
    parameter int unsigned SEGLEN = PN_LEN,
    localparam int unsigned BW = (NBITS > 1) ? $clog2(NBITS) : 1,
    localparam int unsigned CW = (SEGLEN > 1) ? $clog2(SEGLEN) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output tx_state_e     cur_state,
    output logic [BW-1:0] bit_idx,
    output logic [CW-1:0] chip_idx,
    output logic          accept,
    output logic          seg_end,
    output logic          frame_end
);

    localparam logic [CW-1:0] CHIP_LAST = CW'(SEGLEN - 1);
    localparam logic [BW-1:0] BIT_FIRST = BW'(NBITS - 1);

    assign accept    = (cur_state == ST_IDLE) && start;
    assign seg_end   = (cur_state == ST_SEND) && (chip_idx == CHIP_LAST);
    assign frame_end = seg_end && (bit_idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= ST_IDLE;
            bit_idx   <= '0;
            chip_idx  <= '0;
        end else begin
            unique case (cur_state)
                ST_IDLE: begin
                    if (start) begin
                        cur_state <= ST_SEND;
                        bit_idx   <= BIT_FIRST;
                        chip_idx  <= '0;
                    end
                end
                ST_SEND: begin
                    if (chip_idx == CHIP_LAST) begin
                        chip_idx <= '0;
                        if (bit_idx == '0) cur_state <= ST_DONE;
                        else               bit_idx   <= bit_idx - 1'b1;
                    end else begin
                        chip_idx <= chip_idx + 1'b1;
                    end
                end
                ST_DONE: cur_state <= ST_IDLE;
                default: cur_state <= ST_IDLE;
            endcase
        end
    end

    // R9: an idle block without a request stays idle
    a_r9_idle_stays: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_IDLE && !start) |=> (cur_state == ST_IDLE));

    // R6: the chip index never passes the segment length
    a_r6_chip_in_range: assert property (@(posedge clk) disable iff (rst)
        chip_idx <= CHIP_LAST);

endmodule

// File: rtl/dsss_frame_asm.sv
module dsss_frame_asm
    import dsss_pkg::*;
#(
    parameter int unsigned FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          shift_en,
    input  logic          chip_in,
    output logic [FW-1:0] frame
);

    always_ff @(posedge clk) begin
        if (rst || clear)  frame <= '0;
        else if (shift_en) frame <= {frame[FW-2:0], chip_in};
    end

    // R7: the frame holds still when nothing is shifted in
    a_r7_frame_hold: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !clear) |=> $stable(frame));

endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader
    import dsss_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [MSG_W-1:0]   msg_in,
    output logic               chip_out,
    output logic               chip_valid,
    output logic               frame_done,
    output logic [FRAME_W-1:0] frame_out
);

    localparam int unsigned BW = (MSG_W > 1) ? $clog2(MSG_W) : 1;
    localparam int unsigned CW = (PN_LEN > 1) ? $clog2(PN_LEN) : 1;
    localparam logic [PN_W-1:0] SEED_OK = pn_safe_seed(PN_SEED);

    tx_state_e        cur_state;
    logic [BW-1:0]    bit_idx;
    logic [CW-1:0]    chip_idx;
    logic             accept, seg_end, frame_end;
    logic [PN_W-1:0]  pn_state;
    logic             pn_chip;
    logic [MSG_W-1:0] msg_reg;
    logic             sending;

    dsss_seq_ctrl #(.NBITS(MSG_W), .SEGLEN(PN_LEN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cur_state (cur_state),
        .bit_idx   (bit_idx),
        .chip_idx  (chip_idx),
        .accept    (accept),
        .seg_end   (seg_end),
        .frame_end (frame_end)
    );

    assign sending = (cur_state == ST_SEND);

    dsss_pn_gen #(.W(PN_W), .TAPS(PN_TAPS), .SEED(PN_SEED)) u_pn (
        .clk     (clk),
        .rst     (rst),
        .restart (accept || seg_end),
        .advance (sending),
        .state   (pn_state),
        .chip    (pn_chip)
    );

    always_ff @(posedge clk) begin
        if (rst)         msg_reg <= '0;
        else if (accept) msg_reg <= msg_in;
    end

    assign chip_out   = sending & (msg_reg[bit_idx] ~^ pn_chip);
    assign chip_valid = sending;
    assign frame_done = (cur_state == ST_DONE);

    dsss_frame_asm #(.FW(FRAME_W)) u_asm (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .shift_en (sending),
        .chip_in  (chip_out),
        .frame    (frame_out)
    );

    // R2: every segment begins at the seed phase of the code
    a_r2_segment_phase: assert property (@(posedge clk) disable iff (rst)
        (chip_valid && chip_idx == '0) |-> (pn_state == SEED_OK));

    // R7: completion follows the last chip of the last bit
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> frame_done);

    // R7: completion is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R6: chips and completion never share a cycle
    a_r6_valid_not_done: assert property (@(posedge clk) disable iff (rst)
        !(chip_valid && frame_done));

    // R8: the captured message cannot change while a frame is out
    a_r8_msg_locked: assert property (@(posedge clk) disable iff (rst)
        (cur_state != ST_IDLE) |=> $stable(msg_reg));

endmodule

// File: tb/dsss_spreader_test.sv
module dsss_spreader_test;

    localparam int CLK_NS = 20;
    localparam logic [14:0] CODE = 15'b001000111101011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  msg_in = '0;
    logic        chip_out, chip_valid, frame_done;
    logic [59:0] frame_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    dsss_spreader uut (
        .clk(clk), .rst(rst), .start(start), .msg_in(msg_in),
        .chip_out(chip_out), .chip_valid(chip_valid),
        .frame_done(frame_done), .frame_out(frame_out)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_chip(input logic [3:0] m, input int i);
        int seg = i / 15;
        int k = i % 15;
        return m[3-seg] ~^ CODE[14-k];
    endfunction

    function automatic logic [59:0] exp_frame(input logic [3:0] m);
        logic [59:0] f;
        for (int i = 0; i < 60; i++) f[59-i] = exp_chip(m, i);
        return f;
    endfunction

    // Send one frame; inject = 1 raises start mid-frame, 2 raises it on the last chip
    task automatic run_frame(input logic [3:0] m, input int inject);
        logic [59:0] ef;
        ef = exp_frame(m);
        @(negedge clk);
        start = 1'b1; msg_in = m;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 60; i++) begin
            check(chip_valid === 1'b1, "R6 chip_valid", {63'd0, chip_valid}, 64'd1);
            check(chip_out === exp_chip(m, i), "R4 chip", {63'd0, chip_out}, {63'd0, exp_chip(m, i)});
            if (inject == 1 && i == 20) begin start = 1'b1; msg_in = ~m; end
            if (inject == 1 && i == 22) start = 1'b0;
            if (inject == 2 && i == 59) begin start = 1'b1; msg_in = ~m; end
            @(negedge clk);
        end
        check(frame_done === 1'b1, "R7 done pulse", {63'd0, frame_done}, 64'd1);
        check(chip_valid === 1'b0, "R6 valid ends", {63'd0, chip_valid}, 64'd0);
        check(frame_out === ef, "R5 frame", {4'd0, frame_out}, {4'd0, ef});
        @(negedge clk);
        start = 1'b0;
        check(frame_done === 1'b0, "R7 single pulse", {63'd0, frame_done}, 64'd0);
        @(negedge clk);
        check(chip_valid === 1'b0, "R8 no new frame", {63'd0, chip_valid}, 64'd0);
        check(frame_out === ef, "R7 frame held", {4'd0, frame_out}, {4'd0, ef});
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(chip_valid === 1'b0 && frame_done === 1'b0, "R1 reset flags",
              {62'd0, chip_valid, frame_done}, 64'd0);
        check(frame_out === '0, "R1 reset frame", {4'd0, frame_out}, 64'd0);
        rst = 1'b0;
        repeat (5) begin
            @(negedge clk);
            check(chip_valid === 1'b0, "R9 idle", {63'd0, chip_valid}, 64'd0);
        end

        // R2, R4: explicit frames for 1111 and 1010
        run_frame(4'b1111, 0);
        check(frame_out === {4{CODE}}, "R2 code period", {4'd0, frame_out}, {4'd0, {4{CODE}}});
        run_frame(4'b1010, 0);
        check(frame_out === {CODE, ~CODE, CODE, ~CODE}, "R4 1010 pattern",
              {4'd0, frame_out}, {4'd0, CODE, ~CODE, CODE, ~CODE});
        // R5: MSB segment lands in bits 59..45
        run_frame(4'b1000, 0);
        check(frame_out[59:45] === CODE && frame_out[44:0] === {3{~CODE}}, "R5 msb first",
              {4'd0, frame_out}, {4'd0, CODE, {3{~CODE}}});

        // R2, R3: the recurrence c[n+4] = c[n] ^ c[n+3] over the code
        begin
            logic [29:0] two;
            two = {CODE, CODE};
            for (int n = 0; n < 15; n++)
                check(two[29-n-4] === (two[29-n] ^ two[29-n-3]), "R2 recurrence",
                      {63'd0, two[29-n-4]}, {63'd0, two[29-n] ^ two[29-n-3]});
        end

        // Exhaustive sweep of all messages
        for (int m = 0; m < 16; m++) run_frame(4'(m), 0);

        // R8: start during a segment and on the last chip through the done cycle
        run_frame(4'b0110, 1);
        run_frame(4'b1001, 2);
        run_frame(4'b0000, 2);

        // R1, R3: reset in mid-frame, then a clean frame from the seed
        @(negedge clk);
        start = 1'b1; msg_in = 4'b1100;
        @(negedge clk);
        start = 1'b0;
        repeat (17) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(chip_valid === 1'b0 && frame_out === '0, "R1 mid-frame reset",
              {63'd0, chip_valid}, 64'd0);
        rst = 1'b0;
        run_frame(4'b0101, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule